// File: doc/BRIEF.md
# UART Automatic Hardware Handshake Controller

This block handles the modem handshake lines of a UART without software help. On the receive side it compares the receive FIFO fill count with two programmable marks. When the count climbs to the high mark, it releases the active-low request-to-send output. The output is driven low again only after the FIFO has drained to the low mark, so the line does not chatter near a single threshold. When the fill count reaches a separate trigger level, it also raises a receive-data-ready interrupt.

On the transmit side, the active-low clear-to-send input is resynchronised and turned into a start permit for the transmitter. The permit only changes while the transmitter is idle or at the end of a character. A character that has already started is therefore always sent in full. Either side can be switched off: request-to-send then follows a software bit, and the transmitter ignores clear-to-send. The FIFO storage and the serial shifters are outside this block.

Top module: `uart_hw_flow_ctl`

## Requirements
- R1: While `rst_n` is low and for the first cycle after it, `rts_n` is 1 when `auto_rts_en` is 1, `tx_go` is 0 when `auto_cts_en` is 1, and `rx_irq` is 0.
- R2: With `auto_rts_en` set, a fill count greater than or equal to `hi_mark` at a rising edge makes `rts_n` 1 after that edge.
- R3: With `auto_rts_en` set, a fill count less than or equal to `lo_mark` (and below `hi_mark`) at an edge makes `rts_n` 0 after that edge. A count strictly between the marks leaves `rts_n` unchanged.
- R4: With `auto_rts_en` clear, `rts_n` equals the inverse of `rts_soft` in the same cycle. The automatic state returns to released, so after re-enabling, `rts_n` is 1 until the count first reaches `lo_mark`.
- R5: `cts_n` passes through two synchronising flops. With the transmitter idle, a level on `cts_n` appears as `tx_go` equal to its inverse after the third rising edge.
- R6: While `tx_busy` is 1 and `tx_char_done` is 0, `tx_go` holds its value. The synchronised clear-to-send is taken in at an edge where `tx_busy` is 0 or `tx_char_done` is 1.
- R7: With `auto_cts_en` clear, `tx_go` is 1 whatever `cts_n` does.
- R8: `rx_irq` is 1 in the cycle after an edge where the fill count is greater than or equal to `trig_lvl`, and 0 in the cycle after an edge where the count is below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_cnt | input | CW | Receive FIFO fill count |
| hi_mark | input | CW | Fill count that releases request-to-send |
| lo_mark | input | CW | Fill count that re-asserts request-to-send |
| trig_lvl | input | CW | Fill count that raises the data-ready interrupt |
| auto_rts_en | input | 1 | Enables automatic request-to-send |
| auto_cts_en | input | 1 | Enables clear-to-send gating of the transmitter |
| rts_soft | input | 1 | Software request-to-send, 1 = assert, used when automatic mode is off |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_char_done | input | 1 | One-cycle strobe at the end of a character |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_go | output | 1 | Permit for the transmitter to start a new character |
| rx_irq | output | 1 | Receive-data-ready interrupt |

## Verification
The assertions assume that `hi_mark` is strictly greater than `lo_mark` whenever automatic request-to-send is enabled. If the marks crossed, the hysteresis rules of R2 and R3 would contradict each other. They also assume that every input changes away from the rising edge. The bench only writes marks that keep high above low, and drives every input on the falling edge. That includes `cts_n`, even though the block accepts it asynchronously.

// File: rtl/uart_hw_flow_ctl.sv
module uart_hw_flow_ctl #(
  parameter int CW   = 6,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fifo_cnt,
  input  logic [CW-1:0] hi_mark,
  input  logic [CW-1:0] lo_mark,
  input  logic [CW-1:0] trig_lvl,
  input  logic          auto_rts_en,
  input  logic          auto_cts_en,
  input  logic          rts_soft,
  input  logic          cts_n,
  input  logic          tx_busy,
  input  logic          tx_char_done,
  output logic          rts_n,
  output logic          tx_go,
  output logic          rx_irq
);

  logic [SYNC-1:0] cts_sr;
  logic            rts_off;
  logic            cts_gate;

  wire at_hi    = fifo_cnt >= hi_mark;
  wire at_lo    = fifo_cnt <= lo_mark;
  wire boundary = !tx_busy || tx_char_done;

  always_ff @(posedge clk) begin
    if (!rst_n) cts_sr <= '1;
    else        cts_sr <= {cts_sr[SYNC-2:0], cts_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            rts_off <= 1'b1;
    else if (!auto_rts_en) rts_off <= 1'b1;
    else if (at_hi)        rts_off <= 1'b1;
    else if (at_lo)        rts_off <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cts_gate <= 1'b0;
    else if (boundary) cts_gate <= !cts_sr[SYNC-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rx_irq <= 1'b0;
    else        rx_irq <= fifo_cnt >= trig_lvl;
  end

  assign rts_n = auto_rts_en ? rts_off : !rts_soft;
  assign tx_go = !auto_cts_en || cts_gate;

endmodule

module uart_hw_flow_ctl_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] fifo_cnt,
  input logic [CW-1:0] hi_mark,
  input logic [CW-1:0] lo_mark,
  input logic [CW-1:0] trig_lvl,
  input logic          auto_rts_en,
  input logic          auto_cts_en,
  input logic          rts_soft,
  input logic          tx_busy,
  input logic          tx_char_done,
  input logic          rts_n,
  input logic          tx_go,
  input logic          rx_irq
);

  a_r2_release_at_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && auto_rts_en && $past(auto_rts_en) && $past(fifo_cnt >= hi_mark)) |-> rts_n);

  a_r3_assert_at_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && auto_rts_en && $past(auto_rts_en) &&
     $past(fifo_cnt <= lo_mark) && $past(fifo_cnt < hi_mark)) |-> !rts_n);

  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && auto_rts_en && $past(auto_rts_en) &&
     $past(fifo_cnt > lo_mark) && $past(fifo_cnt < hi_mark)) |-> $stable(rts_n));

  a_r4_soft_rts: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |-> (rts_n == !rts_soft));

  a_r6_hold_mid_char: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && auto_cts_en && $past(auto_cts_en) &&
     $past(tx_busy && !tx_char_done)) |-> $stable(tx_go));

  a_r7_cts_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |-> tx_go);

  a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rx_irq == $past(fifo_cnt >= trig_lvl)));

endmodule

bind uart_hw_flow_ctl uart_hw_flow_ctl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_cnt(fifo_cnt), .hi_mark(hi_mark),
  .lo_mark(lo_mark), .trig_lvl(trig_lvl), .auto_rts_en(auto_rts_en),
  .auto_cts_en(auto_cts_en), .rts_soft(rts_soft), .tx_busy(tx_busy),
  .tx_char_done(tx_char_done), .rts_n(rts_n), .tx_go(tx_go), .rx_irq(rx_irq)
);

// File: tb/uart_hw_flow_ctl_test.sv
module uart_hw_flow_ctl_test;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] fifo_cnt = '0, hi_mark = 6'd24, lo_mark = 6'd8, trig_lvl = 6'd16;
  logic auto_rts_en = 1'b1, auto_cts_en = 1'b1, rts_soft = 1'b0, cts_n = 1'b1;
  logic tx_busy = 1'b0, tx_char_done = 1'b0;
  logic rts_n, tx_go, rx_irq;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";
  bit done = 1'b0;

  bit m_off = 1'b1, m_gate = 1'b0, m_irq = 1'b0;
  bit cts_q[$];

  uart_hw_flow_ctl #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_cnt(fifo_cnt), .hi_mark(hi_mark),
    .lo_mark(lo_mark), .trig_lvl(trig_lvl), .auto_rts_en(auto_rts_en),
    .auto_cts_en(auto_cts_en), .rts_soft(rts_soft), .cts_n(cts_n),
    .tx_busy(tx_busy), .tx_char_done(tx_char_done),
    .rts_n(rts_n), .tx_go(tx_go), .rx_irq(rx_irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_off = 1'b1; m_gate = 1'b0; m_irq = 1'b0;
      cts_q = '{1'b1, 1'b1};
    end else begin
      m_irq = fifo_cnt >= trig_lvl;
      if (!auto_rts_en || fifo_cnt >= hi_mark) m_off = 1'b1;
      else if (fifo_cnt <= lo_mark) m_off = 1'b0;
      if (!tx_busy || tx_char_done) m_gate = !cts_q[0];
      void'(cts_q.pop_front());
      cts_q.push_back(cts_n);
    end
  end

  task automatic cmp(string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FIFO-flow FAIL %s %s: actual %0b expected %0b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp("rts_n", rts_n, auto_rts_en ? m_off : !rts_soft);
    cmp("tx_go", tx_go, !auto_cts_en || m_gate);
    cmp("rx_irq", rx_irq, m_irq);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tag = "R1"; step(3); rst_n = 1'b1; step(2);

    tag = "R2";
    for (int i = 0; i <= 32; i++) begin fifo_cnt = i[CW-1:0]; step(); end
    tag = "R3";
    for (int i = 32; i >= 0; i--) begin fifo_cnt = i[CW-1:0]; step(); end
    tag = "R8";
    for (int i = 0; i < 40; i++) begin fifo_cnt = 6'($urandom_range(10, 20)); step(); end

    tag = "R4";
    for (int i = 0; i < 20; i++) begin
      auto_rts_en = 1'b0; rts_soft = $urandom; fifo_cnt = 6'($urandom_range(0, 32)); step();
    end
    fifo_cnt = 6'd15; auto_rts_en = 1'b1; step(3);
    fifo_cnt = 6'd8; step(2);

    tag = "R5";
    for (int i = 0; i < 12; i++) begin cts_n = i[0]; step(1 + i % 4); end
    cts_n = 1'b0; step(4);

    tag = "R6";
    tx_busy = 1'b1; cts_n = 1'b1; step(6);
    tx_char_done = 1'b1; step(); tx_char_done = 1'b0; step(3);
    cts_n = 1'b0; step(6);
    tx_busy = 1'b0; step(2);

    tag = "R7";
    auto_cts_en = 1'b0;
    for (int i = 0; i < 20; i++) begin cts_n = $urandom; tx_busy = $urandom; step(); end

    tag = "R1";
    rst_n = 1'b0; auto_cts_en = 1'b1; auto_rts_en = 1'b1; fifo_cnt = 6'd30; step(2);
    rst_n = 1'b1; step(2);

    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      automatic int lo = $urandom_range(0, 30);
      if (i % 50 == 0) begin
        lo_mark = lo[CW-1:0];
        hi_mark = 6'($urandom_range(lo + 1, 32));
        trig_lvl = 6'($urandom_range(0, 32));
      end
      fifo_cnt = 6'($urandom_range(0, 32));
      auto_rts_en = ($urandom_range(0, 15) != 0);
      auto_cts_en = ($urandom_range(0, 7) != 0);
      rts_soft = $urandom; cts_n = $urandom; tx_busy = $urandom;
      tx_char_done = tx_busy && ($urandom_range(0, 5) == 0);
      step();
    end
    finish_run();
  end
endmodule